// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Companion Word

This block is a purely combinational arithmetic-logic unit for a small processor core. It takes an operation code and two operand words. It returns three things: a main result, a second full-width "companion" word, and a four-bit flag vector. Every operation defines the companion word, so software can build wide or paired results from single instructions:

- For add, the companion word is the carry, which lets a following add fold it into the high word of a double-width sum.
- For multiply, it is the upper half of the product.
- For divide, it is the remainder.
- For a logical right shift, it holds the bits that fell off the bottom, left-aligned, so OR-ing it with the result gives a right rotate.

There is no clock and no state. All outputs follow the inputs within the same evaluation. Decode, the register file and any trap on a zero divisor live outside this block. A zero divisor still yields a fixed, defined pair of words.

Top module: `alu_ext`

## Requirements
- R1: Code 0 (add): result is the low word of a+b; the companion word is the carry-out, 0 or 1.
- R2: Code 1 (subtract): result is the low word of a-b; the companion word is 1 when a < b (unsigned borrow), else 0.
- R3: Codes 2, 3 and 4 (bitwise and, or, xor): result is the bitwise operation; the companion word is zero.
- R4: Code 5 (unsigned multiply): result is bits 31:0 and the companion word is bits 63:32 of the unsigned 64-bit product.
- R5: Code 6 (signed multiply): both operands are two's complement; result and companion word are the low and high words of the signed 64-bit product.
- R6: Code 7 (unsigned divide), nonzero divisor: result is the quotient a/b and the companion word is the remainder a mod b.
- R7: Code 7 with b = 0: result is all ones and the companion word equals a.
- R8: Code 8 (logical right shift by b): result is a >> b and the companion word is a << (32-b) truncated to 32 bits, so result OR companion is a rotated right by b.
- R9: Shift boundaries: b = 0 gives result a and companion 0; b = 32 gives result 0 and companion a; b above 32 continues the 64-bit window {a, 32'b0} >> b (zero once b >= 64).
- R10: Codes 9 to 15 drive zero on the result and the companion word.
- R11: Flag bit 0 is set exactly when the result is zero; flag bit 1 equals result bit 31.
- R12: Flag bit 2 equals companion bit 0 and flag bit 3 is signed overflow of the add or subtract, both for codes 0 and 1 only; for every other code both bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| a | input | 32 | First operand (dividend, value shifted) |
| b | input | 32 | Second operand (divisor, shift amount) |
| result | output | 32 | Main result word |
| ext | output | 32 | Companion word |
| flags | output | 4 | {overflow, carry, negative, zero} |

## Verification
The hardest outputs to reach from the ports are the edges of the shift window and the sign corners of the signed product. These are an amount of exactly 32 or just beyond it, and operands equal to the most negative value. Random operands almost never produce them. The stimulus therefore sweeps every shift amount from 0 to 40 over several patterns, and crosses a fixed set of boundary words (0, 1, all ones, 0x80000000, 0x7fffffff) for every code. Random pairs from a shift-register generator then cover the bulk of the arithmetic.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MULU = 4'd5,
    OP_MULS = 4'd6,
    OP_DIVU = 4'd7,
    OP_SHR  = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } alu_flags_t;

  function automatic logic op_defined(logic [3:0] code);
    return code <= 4'd8;
  endfunction

  function automatic logic op_is_addsub(logic [3:0] code);
    return (code == 4'd0) || (code == 4'd1);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cb_bit,
  output logic         ovf
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] add_wide(logic [W-1:0] p, logic [W-1:0] q, logic inv);
    logic [W-1:0] qq;
    qq = inv ? ~q : q;
    return {1'b0, p} + {1'b0, qq} + {{W{1'b0}}, inv};
  endfunction

  logic [W:0] wide;
  logic       carry_raw;

  always_comb begin
    wide      = add_wide(x, y, do_sub);
    sum       = wide[W-1:0];
    carry_raw = wide[W];
    // subtract: carry of a + ~b + 1 is "no borrow"
    cb_bit    = do_sub ? ~carry_raw : carry_raw;
    if (do_sub)
      ovf = (x[MSB] != y[MSB]) && (sum[MSB] != x[MSB]);
    else
      ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

  always_comb begin
    if (!do_sub) begin
      p_add_carry_r1: assert (cb_bit == (sum < x))
        else $error("add carry does not match wraparound");
    end else begin
      p_sub_borrow_r2: assert (cb_bit == (x < y))
        else $error("subtract borrow does not match compare");
    end
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 32
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] prod_u,
  output logic [2*W-1:0] prod_s,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           div_zero
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] mul_unsigned(logic [W-1:0] p, logic [W-1:0] q);
    return {{W{1'b0}}, p} * {{W{1'b0}}, q};
  endfunction

  function automatic logic [PW-1:0] mul_signed(logic [W-1:0] p, logic [W-1:0] q);
    logic signed [PW-1:0] sp, sq;
    sp = $signed({{W{p[W-1]}}, p});
    sq = $signed({{W{q[W-1]}}, q});
    return $unsigned(sp * sq);
  endfunction

  always_comb begin
    prod_u   = mul_unsigned(x, y);
    prod_s   = mul_signed(x, y);
    div_zero = (y == '0);
    if (div_zero) begin
      quo = '1;
      rem = x;
    end else begin
      quo = x / y;
      rem = x % y;
    end
  end

  // cross-checks between separately computed quantities
  logic [W-1:0]  hi_fix;
  logic [PW-1:0] recon;
  always_comb begin
    hi_fix = prod_u[PW-1:W] - (x[W-1] ? y : '0) - (y[W-1] ? x : '0);
    recon  = {{W{1'b0}}, quo} * {{W{1'b0}}, y} + {{W{1'b0}}, rem};
    p_signed_high_r5: assert (prod_s[PW-1:W] == hi_fix)
      else $error("signed high word disagrees with corrected unsigned high word");
    p_low_equal_r4: assert (prod_s[W-1:0] == prod_u[W-1:0])
      else $error("signed and unsigned low words differ");
    if (!div_zero) begin
      p_div_identity_r6: assert ((recon == {{W{1'b0}}, x}) && (rem < y))
        else $error("quotient*divisor+remainder does not rebuild dividend");
    end else begin
      p_div_zero_r7: assert ((quo == '1) && (rem == x))
        else $error("zero divisor outputs not the defined pair");
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] amt,
  output logic [W-1:0] lo,
  output logic [W-1:0] spill
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] window_shift(logic [W-1:0] v, logic [W-1:0] n);
    return {v, {W{1'b0}}} >> n;
  endfunction

  function automatic logic [PW-1:0] doubled_rot(logic [W-1:0] v, logic [W-1:0] n);
    return {v, v} >> (n % W);
  endfunction

  logic [PW-1:0] win;
  always_comb begin
    win   = window_shift(x, amt);
    lo    = win[PW-1:W];
    spill = win[W-1:0];
  end

  logic [PW-1:0] rot_w;
  always_comb begin
    rot_w = doubled_rot(x, amt);
    if (amt <= W) begin
      p_rotate_r8: assert ((lo | spill) == rot_w[W-1:0])
        else $error("result OR spill is not a right rotate");
    end
    if (amt == '0) begin
      p_shift_zero_r9: assert ((lo == x) && (spill == '0))
        else $error("zero shift altered the word");
    end
    if (amt == W) begin
      p_shift_full_r9: assert ((lo == '0) && (spill == x))
        else $error("full-width shift did not move the word to spill");
    end
  end
endmodule

// File: rtl/alu_ext.sv
module alu_ext
  import alu_ext_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic [W-1:0] ext,
  output logic [3:0]   flags
);
  localparam int PW = 2 * W;

  logic [W-1:0]  as_sum;
  logic          as_cb, as_ovf;
  logic [PW-1:0] md_pu, md_ps;
  logic [W-1:0]  md_q, md_r;
  logic          md_dz;
  logic [W-1:0]  sh_lo, sh_spill;
  logic          is_addsub;
  alu_flags_t    fl;

  alu_addsub #(.W(W)) u_addsub (
    .x(a), .y(b), .do_sub(op == OP_SUB),
    .sum(as_sum), .cb_bit(as_cb), .ovf(as_ovf)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .x(a), .y(b),
    .prod_u(md_pu), .prod_s(md_ps), .quo(md_q), .rem(md_r), .div_zero(md_dz)
  );

  alu_shift #(.W(W)) u_shift (
    .x(a), .amt(b), .lo(sh_lo), .spill(sh_spill)
  );

  always_comb begin
    result = '0;
    ext    = '0;
    case (alu_op_e'(op))
      OP_ADD, OP_SUB: begin result = as_sum;          ext = {{(W-1){1'b0}}, as_cb}; end
      OP_AND:         begin result = a & b;           ext = '0; end
      OP_OR:          begin result = a | b;           ext = '0; end
      OP_XOR:         begin result = a ^ b;           ext = '0; end
      OP_MULU:        begin result = md_pu[W-1:0];    ext = md_pu[PW-1:W]; end
      OP_MULS:        begin result = md_ps[W-1:0];    ext = md_ps[PW-1:W]; end
      OP_DIVU:        begin result = md_q;            ext = md_r; end
      OP_SHR:         begin result = sh_lo;           ext = sh_spill; end
      default:        begin result = '0;              ext = '0; end
    endcase
  end

  always_comb begin
    is_addsub = op_is_addsub(op);
    fl.zero   = (result == '0);
    fl.neg    = result[W-1];
    fl.carry  = is_addsub & ext[0];
    fl.ovf    = is_addsub & as_ovf;
    flags     = fl;
  end

  always_comb begin
    if (!op_defined(op)) begin
      p_unused_zero_r10: assert ((result == '0) && (ext == '0))
        else $error("undefined code drove a nonzero word");
    end
    if ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR)) begin
      p_logic_ext_r3: assert (ext == '0)
        else $error("bitwise op drove the companion word");
    end
    if (!is_addsub) begin
      p_flag_gate_r12: assert (flags[3:2] == 2'b00)
        else $error("carry/overflow flag set outside add/subtract");
    end
    p_zero_flag_r11: assert (flags[0] == ~|result)
      else $error("zero flag disagrees with result");
    if (md_dz && (op == OP_DIVU)) begin
      p_divz_out_r7: assert (ext == a)
        else $error("zero divisor remainder not the dividend");
    end
  end
endmodule

// File: tb/alu_ext_bench.sv
module alu_ext_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]   op = '0;
  logic [W-1:0] a  = '0;
  logic [W-1:0] b  = '0;
  logic [W-1:0] result, ext;
  logic [3:0]   flags;

  alu_ext #(.W(W)) u_alu_ext (
    .op(op), .a(a), .b(b), .result(result), .ext(ext), .flags(flags)
  );

  typedef struct {
    logic [3:0]  op;
    logic [31:0] a, b, res, ext;
    logic [3:0]  fl;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic item_t model(logic [3:0] c, logic [31:0] x, logic [31:0] y, string tag);
    item_t it;
    longint unsigned ux, uy, s;
    longint sx, sy, ss;
    logic v, cy;
    ux = {32'd0, x}; uy = {32'd0, y};
    sx = longint'($signed(x)); sy = longint'($signed(y));
    v = 0; cy = 0;
    it.op = c; it.a = x; it.b = y; it.tag = tag;
    it.res = 0; it.ext = 0;
    case (c)
      4'd0: begin s = ux + uy; it.res = s[31:0]; it.ext = {31'd0, s[32]};
              ss = sx + sy; v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648); cy = s[32]; end
      4'd1: begin it.res = x - y; it.ext = (x < y) ? 32'd1 : 32'd0;
              ss = sx - sy; v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648); cy = (x < y); end
      4'd2: it.res = x & y;
      4'd3: it.res = x | y;
      4'd4: it.res = x ^ y;
      4'd5: begin s = ux * uy; it.res = s[31:0]; it.ext = s[63:32]; end
      4'd6: begin ss = sx * sy; it.res = ss[31:0]; it.ext = ss[63:32]; end
      4'd7: begin
              if (y == 0) begin it.res = 32'hffff_ffff; it.ext = x; end
              else begin it.res = x / y; it.ext = x % y; end
            end
      4'd8: begin
              if (y == 0)       begin it.res = x; it.ext = 0; end
              else if (y < 32)  begin it.res = x >> y; it.ext = x << (32 - y); end
              else if (y == 32) begin it.res = 0; it.ext = x; end
              else if (y < 64)  begin it.res = 0; it.ext = x >> (y - 32); end
            end
      default: ;
    endcase
    it.fl = {v, cy, it.res[31], it.res == 0};
    return it;
  endfunction

  task automatic drive(logic [3:0] c, logic [31:0] x, logic [31:0] y, string tag);
    @(negedge clk);
    op = c; a = x; b = y;
    q.push_back(model(c, x, y, tag));
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what, item_t it);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
               tag, what, it.op, it.a, it.b, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, result, it.res, "result", it);
      check(it.tag, ext, it.ext, "companion", it);
      check("R11 R12", {28'd0, flags}, {28'd0, it.fl}, "flags", it);
    end
  end

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    logic [31:0] edges [5];
    edges = '{32'd0, 32'd1, 32'hffff_ffff, 32'h8000_0000, 32'h7fff_ffff};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time inputs are zero: add of zeros, R11 zero flag set
    drive(4'd0, 32'd0, 32'd0, "R11 reset");
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(c[3:0], edges[i], edges[j], tag_of(c[3:0]));
    // R7 zero divisor
    drive(4'd7, 32'hdead_beef, 32'd0, "R7");
    drive(4'd7, 32'd0, 32'd0, "R7");
    // R9 shift window sweep including 32 and beyond
    for (int n = 0; n <= 40; n++) begin
      drive(4'd8, 32'h8765_4321, n, "R9");
      drive(4'd8, 32'hffff_ffff, n, "R9");
    end
    drive(4'd8, 32'h1234_5678, 32'd64, "R9");
    drive(4'd8, 32'h1234_5678, 32'h8000_0000, "R9");
    // R12 overflow corners
    drive(4'd0, 32'h7fff_ffff, 32'd1, "R12");
    drive(4'd1, 32'h8000_0000, 32'd1, "R12");
    // random pairs for every code
    for (int k = 0; k < 300; k++) begin
      logic [31:0] x, y;
      rng = step(rng); x = rng;
      rng = step(rng); y = rng;
      for (int c = 0; c < 10; c++)
        drive(c[3:0], x, (c == 8) ? {26'd0, y[5:0]} : y, tag_of(c[3:0]));
      drive(4'd7, x, {16'd0, y[15:0]}, "R6");
    end
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule